// File: doc/BRIEF.md
# FP32 to E8M0 Scale Encoder

This block turns one IEEE-754 single-precision number into an 8-bit scale code that holds only a power-of-two exponent. The code has no sign and no mantissa. It is the biased exponent of the input's magnitude, with a bias of 127. Code 0xFF is reserved as the single not-a-number value. The format has no infinity.

The exponent is the integer part of log2|x|, truncated toward zero, not floored. For magnitudes of 1 or more, the code equals the input's exponent field. For a magnitude below 1 that is not an exact power of two, the code is one higher than the exponent field. The block also handles special values. Zero maps to the lowest code and NaN to the reserved code. Infinity saturates to the top finite code. A subnormal input is placed by the position of its highest set mantissa bit. Every finite result is clamped to the range 0 to 254.

One input word with a valid strobe is accepted every cycle. The result appears one clock later with its own valid strobe. While no new input arrives, the last code stays on the output.

Top module: `e8m0_scale_enc`

## Requirements
- R1: An input with exponent field 0 and mantissa 0, of either sign, gives code 0x00.
- R2: An input with exponent field 0xFF and a non-zero mantissa (NaN) gives code 0xFF.
- R3: An input with exponent field 0xFF and mantissa 0 (infinity, either sign) gives code 0xFE.
- R4: A normal input with exponent field e of 127 or more gives code e.
- R5: A normal input with exponent field e below 127 gives code e when its mantissa is zero, and e+1 otherwise.
- R6: Bit 31 (the sign) has no effect on the code.
- R7: For a subnormal input, let p be the index (0 to 22) of the highest set bit of the mantissa in bits 22:0. The code is p-22 when that bit is the only one set, and p-21 otherwise, clamped at 0. The code is therefore 1 only when bit 22 is set together with another bit; every other subnormal gives 0.
- R8: No input with an exponent field other than 0xFF gives code 0xFF, and every finite result lies in 0 to 254.
- R9: out_valid_o equals in_valid_i of the previous clock. The code for an accepted input appears on out_code_o in the same cycle, including for back-to-back inputs.
- R10: While in_valid_i is low, out_code_o keeps its last value.
- R11: While rst_ni is low, out_valid_o is 0 and out_code_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word is valid this cycle |
| in_data_i | input | 32 | Single-precision input value |
| out_valid_o | output | 1 | Output code is new this cycle |
| out_code_o | output | 8 | Power-of-two scale code |

## Verification
The main encoding is tried with several groups of inputs. Exact powers of two and non-powers above 1 show that large magnitudes keep the exponent field unchanged. The same two kinds below 1 show that truncation toward zero adds one only when mantissa bits are set. Subnormals with a lone top bit, a top bit plus a low bit, and only low bits separate the three outcomes of the leading-one rule. Mirrored-sign pairs, the largest finite value, the smallest normals, both infinities and NaNs with a tiny payload check the clamp and the special cases. A back-to-back stream with a gap in it tells a correct one-cycle alignment from a stale or skipped code.

// File: rtl/e8m0_pkg.sv
package e8m0_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } fp_class_e;
endpackage

// File: rtl/e8m0_fp_classify.sv
module e8m0_fp_classify
  import e8m0_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  output fp_class_e        cls_o,
  output logic             man_nz_o
);
  logic exp_ones, exp_zero;

  assign exp_ones = &exp_i;
  assign exp_zero = ~|exp_i;
  assign man_nz_o = |man_i;

  always_comb begin
    if (exp_ones)      cls_o = man_nz_o ? CLS_NAN : CLS_INF;
    else if (exp_zero) cls_o = man_nz_o ? CLS_SUB : CLS_ZERO;
    else               cls_o = CLS_NORM;
  end
endmodule

// File: rtl/e8m0_lead_one.sv
module e8m0_lead_one #(
  parameter int W     = 23,
  localparam int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [POS_W-1:0] pos_o,
  output logic             single_o
);
  logic [W-1:0] above;
  logic [W-1:0] hit;

  assign above[W-1] = 1'b0;
  for (genvar i = 0; i < W - 1; i++) begin : g_above
    assign above[i] = |vec_i[W-1:i+1];
  end

  for (genvar i = 0; i < W; i++) begin : g_hit
    assign hit[i] = vec_i[i] & ~above[i];
  end

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) pos_o = pos_o | POS_W'(i);
    end
  end

  // exactly one bit set: nothing remains once the leading one is removed
  assign single_o = (|vec_i) && ((vec_i & ~hit) == '0);
endmodule

// File: rtl/e8m0_exp_calc.sv
module e8m0_exp_calc
  import e8m0_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  localparam int POS_W = $clog2(MAN_W)
) (
  input  fp_class_e        cls_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             man_nz_i,
  input  logic [POS_W-1:0] lead_pos_i,
  input  logic             lead_single_i,
  output logic [EXP_W-1:0] code_o
);
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int CODE_MAX = (1 << EXP_W) - 2;

  int raw;
  int clamped;

  always_comb begin
    raw = 0;
    unique case (cls_i)
      CLS_NORM: begin
        raw = int'(exp_i);
        // truncation toward zero lifts sub-unity non-powers by one
        if ((int'(exp_i) < BIAS) && man_nz_i) raw = raw + 1;
      end
      CLS_SUB: begin
        raw = int'(lead_pos_i) + 1 - MAN_W;
        if (!lead_single_i) raw = raw + 1;
      end
      default: raw = 0;
    endcase
    if (raw < 0)             clamped = 0;
    else if (raw > CODE_MAX) clamped = CODE_MAX;
    else                     clamped = raw;
  end

  always_comb begin
    unique case (cls_i)
      CLS_NAN:  code_o = '1;
      CLS_INF:  code_o = EXP_W'(CODE_MAX);
      CLS_ZERO: code_o = '0;
      default:  code_o = EXP_W'(clamped);
    endcase
  end
endmodule

// File: rtl/e8m0_scale_enc.sv
module e8m0_scale_enc
  import e8m0_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  localparam int DATA_W = EXP_W + MAN_W + 1,
  localparam int POS_W  = $clog2(MAN_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [EXP_W-1:0]  out_code_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             unused_sign;
  fp_class_e        cls;
  logic             man_nz;
  logic [POS_W-1:0] lead_pos;
  logic             lead_single;
  logic [EXP_W-1:0] code_d;

  assign unused_sign = in_data_i[DATA_W-1];
  assign exp_f       = in_data_i[DATA_W-2:MAN_W];
  assign man_f       = in_data_i[MAN_W-1:0];

  e8m0_fp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
    .exp_i    (exp_f),
    .man_i    (man_f),
    .cls_o    (cls),
    .man_nz_o (man_nz)
  );

  e8m0_lead_one #(.W(MAN_W)) u_lead_one (
    .vec_i    (man_f),
    .pos_o    (lead_pos),
    .single_o (lead_single)
  );

  e8m0_exp_calc #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_exp_calc (
    .cls_i         (cls),
    .exp_i         (exp_f),
    .man_nz_i      (man_nz),
    .lead_pos_i    (lead_pos),
    .lead_single_i (lead_single),
    .code_o        (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_code_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_code_o <= code_d;
    end
  end
endmodule

// File: rtl/e8m0_scale_enc_chk.sv
module e8m0_scale_enc_chk #(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  localparam int DATA_W = EXP_W + MAN_W + 1,
  localparam int CODE_MAX = (1 << EXP_W) - 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic [EXP_W-1:0]  out_code_o
);
  logic [EXP_W-1:0] exp_f;
  logic             man_nz;
  logic             mag_zero;

  assign exp_f    = in_data_i[DATA_W-2:MAN_W];
  assign man_nz   = |in_data_i[MAN_W-1:0];
  assign mag_zero = ~|in_data_i[DATA_W-2:0];

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (out_valid_o == $past(in_valid_i)));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(in_valid_i)) |-> $stable(out_code_o));

  p_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mag_zero) |=> (out_code_o == '0));

  p_nan_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (&exp_f) && man_nz) |=> (out_code_o == '1));

  p_inf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (&exp_f) && !man_nz) |=> (out_code_o == EXP_W'(CODE_MAX)));

  p_finite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !(&exp_f)) |=> (out_code_o != '1));
endmodule

bind e8m0_scale_enc e8m0_scale_enc_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_code_o  (out_code_o)
);

// File: tb/e8m0_scale_enc_bench.sv
`timescale 1ns/100ps
module e8m0_scale_enc_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        out_valid_o;
  logic [7:0]  out_code_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  e8m0_scale_enc u_e8m0_scale_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .out_code_o  (out_code_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // drive one word, check valid and code one clock later
  task automatic send(input string req, input logic [31:0] d, input logic [7:0] exp);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = d;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk({req, " valid"}, 32'(out_valid_o), 32'd1);
    chk({req, " code"}, 32'(out_code_o), 32'(exp));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk("R11 valid in reset", 32'(out_valid_o), 32'd0);
    chk("R11 code in reset", 32'(out_code_o), 32'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_zero();
    send("R1 +0", 32'h0000_0000, 8'h00);
    send("R1 -0", 32'h8000_0000, 8'h00);
  endtask

  task automatic t_nan();
    send("R2 qnan", 32'h7FC0_0000, 8'hFF);
    send("R2 -nan tiny payload", 32'hFF80_0001, 8'hFF);
  endtask

  task automatic t_inf();
    send("R3 +inf", 32'h7F80_0000, 8'hFE);
    send("R3 -inf", 32'hFF80_0000, 8'hFE);
  endtask

  task automatic t_ge_one();
    send("R4 1.0", 32'h3F80_0000, 8'h7F);
    send("R4 1.5", 32'h3FC0_0000, 8'h7F);
    send("R4 3.0", 32'h4040_0000, 8'h80);
    send("R4 65536", 32'h4780_0000, 8'h8F);
  endtask

  task automatic t_lt_one();
    send("R5 0.5", 32'h3F00_0000, 8'h7E);
    send("R5 0.75", 32'h3F40_0000, 8'h7F);
    send("R5 0.25+ulp", 32'h3E80_0001, 8'h7E);
    send("R5 min normal", 32'h0080_0000, 8'h01);
    send("R5 min normal+ulp", 32'h0080_0001, 8'h02);
  endtask

  task automatic t_sign();
    send("R6 -1.5", 32'hBFC0_0000, 8'h7F);
    send("R6 -0.75", 32'hBF40_0000, 8'h7F);
    send("R6 -3.0", 32'hC040_0000, 8'h80);
  endtask

  task automatic t_sub();
    send("R7 top bit only", 32'h0040_0000, 8'h00);
    send("R7 top bit plus low", 32'h0040_0001, 8'h01);
    send("R7 neg top two bits", 32'h8060_0000, 8'h01);
    send("R7 next bit plus low", 32'h0020_0001, 8'h00);
    send("R7 smallest", 32'h0000_0001, 8'h00);
  endtask

  task automatic t_clamp();
    send("R8 max finite", 32'h7F7F_FFFF, 8'hFE);
    send("R8 neg max finite", 32'hFF7F_FFFF, 8'hFE);
  endtask

  // back-to-back inputs with one gap; each result checked one clock later
  task automatic t_stream();
    logic [31:0] d [6] = '{32'h3F80_0000, 32'h4040_0000, 32'h0000_0000,
                           32'h7FC0_0000, 32'h3F40_0000, 32'h7F80_0000};
    logic [7:0]  e [6] = '{8'h7F, 8'h80, 8'h00, 8'hFF, 8'h7F, 8'hFE};
    bit          v [6] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    logic [7:0]  last = out_code_o;
    for (int i = 0; i <= 6; i++) begin
      @(negedge clk_i);
      if (i > 0) begin
        chk("R9 stream valid", 32'(out_valid_o), 32'(v[i-1]));
        if (v[i-1]) last = e[i-1];
        chk("R9 stream code", 32'(out_code_o), 32'(last));
      end
      if (i < 6) begin
        in_valid_i = v[i];
        in_data_i  = d[i];
      end else begin
        in_valid_i = 1'b0;
      end
    end
  endtask

  task automatic t_hold();
    send("R10 load", 32'h4040_0000, 8'h80);
    @(negedge clk_i);
    in_data_i = 32'h7FC0_0000;
    repeat (3) begin
      @(negedge clk_i);
      chk("R10 held code", 32'(out_code_o), 32'h80);
      chk("R10 valid low", 32'(out_valid_o), 32'd0);
    end
  endtask

  task automatic t_midreset();
    send("R11 preload", 32'h4780_0000, 8'h8F);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = 32'h3F80_0000;
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R11 async valid", 32'(out_valid_o), 32'd0);
    chk("R11 async code", 32'(out_code_o), 32'd0);
    @(negedge clk_i);
    chk("R11 held in reset", 32'(out_valid_o), 32'd0);
    in_valid_i = 1'b0;
    rst_ni = 1'b1;
    send("R11 after reset", 32'h3F80_0000, 8'h7F);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_nan();
    t_inf();
    t_ge_one();
    t_lt_one();
    t_sign();
    t_sub();
    t_clamp();
    t_stream();
    t_hold();
    t_midreset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule